// File: doc/BRIEF.md
# Funnel Shifter Datapath Unit

A purely combinational shifter for a WIDTH-bit operand that covers logical, arithmetic and rotate shifts in both directions with a single selection network. From the operand and a fill pattern chosen by the direction and the kind of shift, it forms a double-width word. It then takes a WIDTH-bit window out of that word. The window's position follows from the shift amount.

The window is selected by a cascade of log2(WIDTH) stages of two-input multiplexers. Bit i of the steering value drives stage i, so the shift amount needs no decoding. For a right shift, the steering value is the amount itself. For a left shift, the double-width word is first moved down by one place and the steering value is the bitwise inverse of the amount, which places the window at WIDTH minus the amount. The unit holds no state. It sits in an execution datapath between operand selection and result writeback.

Top module: `funnel_shifter`

## Requirements
- R1: With kind code 2'b00 (logical) and dir_left_i = 0, result_o equals operand_i shifted right by amount_i, and the vacated upper bits are 0.
- R2: With kind code 2'b01 (arithmetic) and dir_left_i = 0, result_o equals operand_i shifted right by amount_i, and the vacated upper bits are copies of operand_i[WIDTH-1].
- R3: With kind code 2'b10 (rotate) and dir_left_i = 0, bit j of result_o equals bit (j + amount_i) mod WIDTH of operand_i.
- R4: With kind code 2'b00 and dir_left_i = 1, result_o equals operand_i shifted left by amount_i, and the vacated lower bits are 0.
- R5: With kind code 2'b01 and dir_left_i = 1, result_o is identical to the logical left shift of the same operand and amount.
- R6: With kind code 2'b10 and dir_left_i = 1, bit (j + amount_i) mod WIDTH of result_o equals bit j of operand_i.
- R7: When amount_i is 0, result_o equals operand_i for every kind and both directions.
- R8: Kind code 2'b11 behaves exactly as the logical shift (2'b00) in both directions.
- R9: result_o depends only on the present inputs. There is no clock and no retained state, and the result is valid in the same cycle in which the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | WIDTH | Value to be shifted |
| amount_i | input | $clog2(WIDTH) | Shift distance, 0 to WIDTH-1 |
| dir_left_i | input | 1 | 1 = shift toward the MSB, 0 = toward the LSB |
| kind_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| result_o | output | WIDTH | Shifted value |

## Verification
The block holds no state, so any internal fault appears at result_o in the same cycle as the input that triggers it. A wrong fill choice shows up as bad upper bits on right shifts, or bad lower bits on left shifts, once the amount is nonzero. A wrong steering bit or stage step corrupts every amount whose binary form uses that bit. The bench therefore sweeps every amount for every kind and direction and compares against behavioural shift operators. It adds directed vectors for amounts of 0 and WIDTH-1 and for operands with the sign bit set.

// File: rtl/fs_pkg.sv
package fs_pkg;

    typedef enum logic [1:0] {
        SK_LOGICAL   = 2'b00,
        SK_ARITH     = 2'b01,
        SK_ROTATE    = 2'b10,
        SK_LOGICAL_B = 2'b11
    } shift_kind_e;

    function automatic logic kind_is_rotate(input shift_kind_e k);
        return (k == SK_ROTATE);
    endfunction

    function automatic logic kind_is_arith(input shift_kind_e k);
        return (k == SK_ARITH);
    endfunction

endpackage

// File: rtl/fs_word_former.sv
module fs_word_former
    import fs_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   operand,
    input  logic [AMT_W-1:0]   amount,
    input  logic               dir_left,
    input  shift_kind_e        kind,
    output logic [2*WIDTH-1:0] word,
    output logic [AMT_W-1:0]   steer
);

    logic [WIDTH-1:0]   fill;
    logic [2*WIDTH-1:0] raw;

    always_comb begin
        // Rotate wraps the operand; arithmetic right replicates the sign;
        // everything else shifts in zeros.
        if (kind_is_rotate(kind))
            fill = operand;
        else if (kind_is_arith(kind) && !dir_left && operand[WIDTH-1])
            fill = '1;
        else
            fill = '0;

        raw = dir_left ? {operand, fill} : {fill, operand};

        // Left: pre-move down one place so ~amount lands on WIDTH-amount.
        word  = dir_left ? {1'b0, raw[2*WIDTH-1:1]} : raw;
        steer = dir_left ? ~amount : amount;
    end

endmodule

// File: rtl/fs_mux_stage.sv
module fs_mux_stage #(
    parameter int DW   = 64,
    parameter int STEP = 1
) (
    input  logic [DW-1:0] din,
    input  logic          sel,
    output logic [DW-1:0] dout
);

    assign dout = sel ? (din >> STEP) : din;

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
    import fs_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]         operand_i,
    input  logic [$clog2(WIDTH)-1:0] amount_i,
    input  logic                     dir_left_i,
    input  logic [1:0]               kind_i,
    output logic [WIDTH-1:0]         result_o
);

    localparam int AMT_W = $clog2(WIDTH);
    localparam int DW    = 2 * WIDTH;

    logic [DW-1:0]    word;
    logic [AMT_W-1:0] steer;
    logic [DW-1:0]    stage_w [0:AMT_W];
    logic             unused_upper;

    fs_word_former #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_former (
        .operand  (operand_i),
        .amount   (amount_i),
        .dir_left (dir_left_i),
        .kind     (shift_kind_e'(kind_i)),
        .word     (word),
        .steer    (steer)
    );

    assign stage_w[0] = word;

    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
        fs_mux_stage #(.DW(DW), .STEP(1 << i)) u_stage (
            .din  (stage_w[i]),
            .sel  (steer[i]),
            .dout (stage_w[i+1])
        );
    end

    assign result_o     = stage_w[AMT_W][WIDTH-1:0];
    assign unused_upper = ^stage_w[AMT_W][DW-1:WIDTH];

endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0]         operand_i,
    input logic [$clog2(WIDTH)-1:0] amount_i,
    input logic                     dir_left_i,
    input logic [1:0]               kind_i,
    input logic [WIDTH-1:0]         result_o
);

    logic [WIDTH-1:0] mask_hi;
    logic [WIDTH-1:0] mask_lo;

    always_comb begin
        mask_hi = ~({WIDTH{1'b1}} >> amount_i);
        mask_lo = ~({WIDTH{1'b1}} << amount_i);

        if (amount_i == '0)
            assert_zero_amount_R7: assert (result_o == operand_i);

        if (kind_i == 2'b10 && !dir_left_i)
            assert_rotate_right_bits_R3: assert ($countones(result_o) == $countones(operand_i));

        if (kind_i == 2'b10 && dir_left_i)
            assert_rotate_left_bits_R6: assert ($countones(result_o) == $countones(operand_i));

        if ((kind_i == 2'b00 || kind_i == 2'b11) && !dir_left_i)
            assert_logical_right_fill_R1: assert ((result_o & mask_hi) == '0);

        if (kind_i == 2'b01 && !dir_left_i)
            assert_arith_right_fill_R2: assert ((result_o & mask_hi) ==
                                               (operand_i[WIDTH-1] ? mask_hi : '0));

        if ((kind_i == 2'b00 || kind_i == 2'b11) && dir_left_i)
            assert_logical_left_fill_R4: assert ((result_o & mask_lo) == '0);

        if (kind_i == 2'b01 && dir_left_i)
            assert_arith_left_fill_R5: assert ((result_o & mask_lo) == '0);
    end

endmodule

bind funnel_shifter fs_checker #(.WIDTH(WIDTH)) u_fs_checker (
    .operand_i  (operand_i),
    .amount_i   (amount_i),
    .dir_left_i (dir_left_i),
    .kind_i     (kind_i),
    .result_o   (result_o)
);

// File: tb/tb_funnel_shifter.sv
module tb_funnel_shifter;

    localparam int WIDTH = 32;
    localparam int AMT_W = 5;
    localparam int NVEC  = 14;
    // {operand, amount, dir_left, kind, expected}
    localparam int VW    = WIDTH + AMT_W + 1 + 2 + WIDTH;

    localparam logic [VW-1:0] VEC [0:NVEC-1] = '{
        {32'h80000001, 5'd1,  1'b0, 2'b00, 32'h40000000},   // R1
        {32'h80000001, 5'd1,  1'b0, 2'b01, 32'hC0000000},   // R2
        {32'h80000001, 5'd1,  1'b0, 2'b10, 32'hC0000000},   // R3
        {32'h80000001, 5'd1,  1'b1, 2'b00, 32'h00000002},   // R4
        {32'h80000001, 5'd1,  1'b1, 2'b10, 32'h00000003},   // R6
        {32'h80000001, 5'd1,  1'b1, 2'b01, 32'h00000002},   // R5
        {32'h12345678, 5'd4,  1'b0, 2'b10, 32'h81234567},   // R3
        {32'h12345678, 5'd4,  1'b1, 2'b10, 32'h23456781},   // R6
        {32'hF0000000, 5'd31, 1'b0, 2'b01, 32'hFFFFFFFF},   // R2
        {32'h7FFFFFFF, 5'd31, 1'b0, 2'b01, 32'h00000000},   // R2
        {32'h00000001, 5'd31, 1'b1, 2'b00, 32'h80000000},   // R4
        {32'hDEADBEEF, 5'd0,  1'b0, 2'b01, 32'hDEADBEEF},   // R7
        {32'hDEADBEEF, 5'd0,  1'b1, 2'b10, 32'hDEADBEEF},   // R7
        {32'h80000000, 5'd31, 1'b0, 2'b11, 32'h00000001}    // R8
    };

    logic             clk;
    logic             rst;
    logic [WIDTH-1:0] operand_i;
    logic [AMT_W-1:0] amount_i;
    logic             dir_left_i;
    logic [1:0]       kind_i;
    logic [WIDTH-1:0] result_o;

    int checks;
    int failures;
    bit done;

    funnel_shifter #(.WIDTH(WIDTH)) dut (
        .operand_i  (operand_i),
        .amount_i   (amount_i),
        .dir_left_i (dir_left_i),
        .kind_i     (kind_i),
        .result_o   (result_o)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [WIDTH-1:0] ref_model(input logic [WIDTH-1:0] a,
                                                   input int k, input logic left,
                                                   input logic [1:0] kind);
        logic [WIDTH-1:0] r;
        if (kind == 2'b10) begin
            if (k == 0) r = a;
            else if (left) r = (a << k) | (a >> (WIDTH - k));
            else r = (a >> k) | (a << (WIDTH - k));
        end else if (left) begin
            r = a << k;
        end else if (kind == 2'b01) begin
            r = $unsigned($signed(a) >>> k);
        end else begin
            r = a >> k;
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] kind, input logic left, input int k);
        if (k == 0) return "R7";
        if (kind == 2'b11) return "R8";
        case ({left, kind})
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b100:  return "R4";
            3'b101:  return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply_and_check(input logic [WIDTH-1:0] a, input int k,
                                   input logic left, input logic [1:0] kind,
                                   input logic [WIDTH-1:0] exp, input string tag);
        @(posedge clk);
        operand_i  = a;
        amount_i   = AMT_W'(k);
        dir_left_i = left;
        kind_i     = kind;
        @(negedge clk);
        checks++;
        if (result_o !== exp) begin
            failures++;
            $display("FAIL %s: a=%h k=%0d left=%0b kind=%0b actual=%h expected=%h",
                     tag, a, k, left, kind, result_o, exp);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        checks = 0;
        failures = 0;
        done = 1'b0;
        rst = 1'b1;
        operand_i = '0;
        amount_i = '0;
        dir_left_i = 1'b0;
        kind_i = 2'b00;
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // Idle inputs: zero operand gives zero result with no history (R9)
        @(negedge clk);
        checks++;
        if (result_o !== '0) begin
            failures++;
            $display("FAIL R9: actual=%h expected=%h", result_o, 32'h0);
        end

        // Directed table
        for (int i = 0; i < NVEC; i++) begin
            logic [WIDTH-1:0] va;
            logic [AMT_W-1:0] vk;
            logic             vl;
            logic [1:0]       vkind;
            logic [WIDTH-1:0] vexp;
            {va, vk, vl, vkind, vexp} = VEC[i];
            apply_and_check(va, int'(vk), vl, vkind, vexp, tag_of(vkind, vl, int'(vk)));
        end

        // R9: result follows a new input in the same cycle, no memory of the old one
        apply_and_check(32'hA5A5A5A5, 8, 1'b1, 2'b10, 32'hA5A5A5A5, "R9");
        apply_and_check(32'h00000000, 8, 1'b1, 2'b10, 32'h00000000, "R9");

        // Sweep: every kind, direction and amount over random operands
        for (int kind = 0; kind < 4; kind++) begin
            for (int left = 0; left < 2; left++) begin
                for (int k = 0; k < WIDTH; k++) begin
                    for (int r = 0; r < 4; r++) begin
                        logic [WIDTH-1:0] a;
                        a = $urandom();
                        if (r == 0) a[WIDTH-1] = 1'b1;
                        if (r == 1) a[WIDTH-1] = 1'b0;
                        apply_and_check(a, k, left[0], kind[1:0],
                                        ref_model(a, k, left[0], kind[1:0]),
                                        tag_of(kind[1:0], left[0], k));
                    end
                end
            end
        end

        // R5: arithmetic left matches logical left for the same operand
        for (int k = 0; k < WIDTH; k++) begin
            logic [WIDTH-1:0] a;
            a = $urandom() | 32'h80000000;
            apply_and_check(a, k, 1'b1, 2'b01, a << k, "R5");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule